// File: doc/BRIEF.md
# Two-Wire Switch-Control Slave

This block is a slave on a two-wire serial bus (I2C-compatible). It holds one 8-bit control register whose bits drive eight switch-enable outputs directly. A bus master addresses the slave with a 7-bit address. The two low address bits come from strap inputs, so up to four of these slaves can share one bus. After addressing, the master either writes control bytes or reads back the live register value.

Both bus lines are sampled with the system clock, passed through a synchronizer and a stability filter, and then searched for START, repeated START and STOP conditions. The slave never drives SDA high. It only asserts an output enable that pulls the line low, and an external resistor pulls the line up. Clock stretching, general call and 10-bit addressing are not part of the block.

Top module: `tw_switch_slave`

## Requirements
- R1: While the active-low clear input is low, and after it is released, all switch outputs are 0 and the SDA pull-down is released.
- R2: An address byte whose upper seven bits equal 1,0,0,1,0,A1,A0 (A1 and A0 are the strap input values, the address is sent MSB first, and the eighth bit is R/W) is acknowledged by pulling SDA low during the ninth clock.
- R3: After an address byte that does not match, the slave never pulls SDA low and ignores all further bytes until the next START.
- R4: In a write (R/W = 0), each data byte is acknowledged. The byte is copied to the switch outputs at the falling SCL edge after its eighth bit, and the first bit sent lands on output bit 7.
- R5: A write transaction can carry any number of data bytes, and each byte updates the outputs again.
- R6: In a read (R/W = 1), the slave shifts out the current register value, MSB first, changing SDA only after SCL falling edges.
- R7: When the master acknowledges a read byte (SDA low on the ninth clock), the slave sends the register again. A master no-acknowledge ends the read, and the slave releases SDA and returns to idle.
- R8: A repeated START in the middle of a transaction returns the slave to address reception and leaves the register unchanged.
- R9: After a STOP, clock pulses and data without a new START have no effect on the outputs or on SDA.
- R10: A pulse on SCL or SDA shorter than FILTER_CLKS system clocks is ignored. This includes an SDA pulse while SCL is high, which would otherwise look like a START or STOP.
- R11: The value the slave drives on SDA never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Active-low asynchronous clear and power-up reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level, as seen on the wire |
| strapA1 | input | 1 | Strap input for address bit 1 |
| strapA0 | input | 1 | Strap input for address bit 0 (LSB) |
| sdaDriveLow | output | 1 | Open-drain enable; 1 pulls SDA low |
| swEn | output | 8 | Switch-enable outputs, one bit per switch |

## Verification
Each strap setting is paired with its own matching address, and with addresses that differ in a strap bit or in the fixed prefix. This shows whether the full seven-bit compare is made, or only part of it. Data bytes of alternating, all-ones, all-zeros and single-end-bit patterns expose bit-order and shift-direction faults in both the write and the read paths. Multi-byte writes, acknowledged back-to-back reads, repeated STARTs and bits sent after a STOP separate correct state handling from a slave that only works for single-byte transfers. Sub-threshold pulses placed on SDA while SCL is high, and on SCL while it is low, show whether the filter removes false conditions and extra clocks.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } twsState_t;

  // Per-cycle commands from the control FSM to the datapath.
  typedef struct packed {
    logic shiftRx;  // take one bit from SDA into the receive shifter
    logic commit;   // copy the receive shifter into the control register
    logic loadTx;   // load the transmit shifter and drive its MSB
    logic shiftTx;  // advance the transmit shifter and drive the next bit
    logic ackLow;   // pull SDA low for an acknowledge
    logic relSda;   // let SDA go
  } twsStrobe_t;

endpackage

// File: rtl/tws_glitch_filter.sv
module tws_glitch_filter #(
  parameter int STABLE_CLKS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);

  localparam int CNT_W = $clog2(STABLE_CLKS + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       runCnt;
  logic                   level;
  logic                   syncd;

  assign syncd = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
    end
  end

  // A new level is taken only after STABLE_CLKS consecutive samples disagree.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level  <= 1'b1;
      runCnt <= '0;
    end else if (syncd == level) begin
      runCnt <= '0;
    end else if (runCnt == CNT_W'(STABLE_CLKS - 1)) begin
      level  <= syncd;
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign cleanOut = level;

endmodule

// File: rtl/tws_control.sv
module tws_control
  import tws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic       addrMatch,
  input  logic       rwBit,
  output twsStrobe_t strobe,
  output logic       busIdle
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  twsState_t        state, stNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic             readMode, rwNext;
  logic             masterAck, mAckNext;
  logic             sclPrev, sdaPrev;
  logic             sclRise, sclFall, startSeen, stopSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  assign sclRise   = sclF & ~sclPrev;
  assign sclFall   = ~sclF & sclPrev;
  assign startSeen = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopSeen  = sclF & sclPrev & ~sdaPrev & sdaF;

  always_comb begin
    strobe   = '0;
    stNext   = state;
    cntNext  = bitCnt;
    rwNext   = readMode;
    mAckNext = masterAck;
    if (startSeen) begin
      strobe.relSda = 1'b1;
      stNext        = ST_ADDR;
      cntNext       = '0;
    end else if (stopSeen) begin
      strobe.relSda = 1'b1;
      stNext        = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_WDATA: begin
          if (sclRise && bitCnt < CNT_W'(BYTE_BITS)) begin
            strobe.shiftRx = 1'b1;
            cntNext        = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == CNT_W'(BYTE_BITS)) begin
            if (state == ST_ADDR) begin
              if (addrMatch) begin
                strobe.ackLow = 1'b1;
                rwNext        = rwBit;
                stNext        = ST_AACK;
              end else begin
                stNext = ST_IDLE;
              end
            end else begin
              strobe.commit = 1'b1;
              strobe.ackLow = 1'b1;
              stNext        = ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            cntNext = '0;
            if (readMode) begin
              strobe.loadTx = 1'b1;
              stNext        = ST_RDATA;
            end else begin
              strobe.relSda = 1'b1;
              stNext        = ST_WDATA;
            end
          end
        end
        ST_WACK: begin
          if (sclFall) begin
            strobe.relSda = 1'b1;
            cntNext       = '0;
            stNext        = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            cntNext = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == CNT_W'(BYTE_BITS)) begin
              strobe.relSda = 1'b1;
              stNext        = ST_RACK;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            mAckNext = ~sdaF;
          end else if (sclFall) begin
            cntNext = '0;
            if (masterAck) begin
              strobe.loadTx = 1'b1;
              stNext        = ST_RDATA;
            end else begin
              strobe.relSda = 1'b1;
              stNext        = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stNext;
      bitCnt    <= cntNext;
      readMode  <= rwNext;
      masterAck <= mAckNext;
    end
  end

  assign busIdle = (state == ST_IDLE);

endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int                PREFIX_W    = 5,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b10010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  twsStrobe_t           strobe,
  input  logic                 sdaF,
  input  logic                 strapHi,
  input  logic                 strapLo,
  output logic                 addrMatch,
  output logic                 rwBit,
  output logic                 sdaLow,
  output logic [BYTE_BITS-1:0] swReg
);

  localparam int ADDR_W = PREFIX_W + 2;

  logic [BYTE_BITS-1:0] rxShift, txShift, ctrlReg;
  logic                 sdaLowQ;

  assign addrMatch = (rxShift[BYTE_BITS-1 -: ADDR_W] == {ADDR_PREFIX, strapHi, strapLo});
  assign rwBit     = rxShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      ctrlReg <= '0;
    end else begin
      if (strobe.shiftRx) rxShift <= {rxShift[BYTE_BITS-2:0], sdaF};
      if (strobe.commit)  ctrlReg <= rxShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      sdaLowQ <= 1'b0;
    end else if (strobe.relSda) begin
      sdaLowQ <= 1'b0;
    end else if (strobe.ackLow) begin
      sdaLowQ <= 1'b1;
    end else if (strobe.loadTx) begin
      txShift <= ctrlReg;
      sdaLowQ <= ~ctrlReg[BYTE_BITS-1];
    end else if (strobe.shiftTx) begin
      txShift <= {txShift[BYTE_BITS-2:0], 1'b0};
      sdaLowQ <= ~txShift[BYTE_BITS-2];
    end
  end

  assign sdaLow = sdaLowQ;
  assign swReg  = ctrlReg;

endmodule

// File: rtl/tw_switch_slave.sv
module tw_switch_slave
  import tws_pkg::*;
#(
  parameter int        FILTER_CLKS = 4,
  parameter int        SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b10010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 strapA1,
  input  logic                 strapA0,
  output logic                 sdaDriveLow,
  output logic [BYTE_BITS-1:0] swEn
);

  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawLines, cleanLines;
  logic                 sclClean, sdaClean;
  logic                 addrMatch, rwBit, busIdle;
  twsStrobe_t           strobe;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    tws_glitch_filter #(
      .STABLE_CLKS(FILTER_CLKS),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_filt (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawLines[g]),
      .cleanOut(cleanLines[g])
    );
  end

  assign sclClean = cleanLines[1];
  assign sdaClean = cleanLines[0];

  tws_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .sclF     (sclClean),
    .sdaF     (sdaClean),
    .addrMatch(addrMatch),
    .rwBit    (rwBit),
    .strobe   (strobe),
    .busIdle  (busIdle)
  );

  tws_datapath #(
    .PREFIX_W   (5),
    .ADDR_PREFIX(ADDR_PREFIX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sdaF     (sdaClean),
    .strapHi  (strapA1),
    .strapLo  (strapA0),
    .addrMatch(addrMatch),
    .rwBit    (rwBit),
    .sdaLow   (sdaDriveLow),
    .swReg    (swEn)
  );

endmodule

// File: rtl/tw_switch_slave_chk.sv
module tw_switch_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclF,
  input logic       busIdle,
  input logic       sdaDriveLow,
  input logic [7:0] swEn
);

  // R1: held clear while the clear input is low
  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_clear_state: assert (swEn == 8'h00 && !sdaDriveLow)
        else $error("R1 outputs not clear during reset");
    end
  end

  a_r11_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclF && $past(sclF)) |-> $stable(sdaDriveLow));

  a_r4_update_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(swEn) |-> !sclF);

  a_r3_idle_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> !sdaDriveLow);

endmodule

bind tw_switch_slave tw_switch_slave_chk chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclF       (sclClean),
  .busIdle    (busIdle),
  .sdaDriveLow(sdaDriveLow),
  .swEn       (swEn)
);

// File: tb/tw_switch_slave_test.sv
module tw_switch_slave_test;

  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterScl = 1'b1;
  logic       masterSda = 1'b1;
  logic       strapA1 = 1'b0;
  logic       strapA0 = 1'b0;
  logic       sdaDriveLow;
  logic [7:0] swEn;
  wire        sdaLine = masterSda & ~sdaDriveLow;

  int checks = 0;
  int fails = 0;
  int driveCount = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (sdaDriveLow) driveCount <= driveCount + 1;

  tw_switch_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(masterScl), .sdaIn(sdaLine),
    .strapA1(strapA1), .strapA0(strapA0),
    .sdaDriveLow(sdaDriveLow), .swEn(swEn)
  );

  // {strap A1,A0, address byte, data byte, expected ack, expected switches}
  localparam logic [26:0] VEC [8] = '{
    {2'b00, 8'h90, 8'hA5, 1'b1, 8'hA5},
    {2'b01, 8'h92, 8'h3C, 1'b1, 8'h3C},
    {2'b10, 8'h94, 8'hFF, 1'b1, 8'hFF},
    {2'b11, 8'h96, 8'h00, 1'b1, 8'h00},
    {2'b11, 8'h90, 8'h5A, 1'b0, 8'h00},
    {2'b00, 8'hB0, 8'h77, 1'b0, 8'h00},
    {2'b00, 8'h90, 8'h81, 1'b1, 8'h81},
    {2'b00, 8'h10, 8'h18, 1'b0, 8'h81}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    masterSda = 1'b1; waitQ();
    masterScl = 1'b1; waitQ();
    masterSda = 1'b0; waitQ();
    masterScl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    masterSda = 1'b0; waitQ();
    masterScl = 1'b1; waitQ();
    masterSda = 1'b1; waitQ();
  endtask

  task automatic writeBit(input logic b);
    masterSda = b; waitQ();
    masterScl = 1'b1; waitQ(); waitQ();
    masterScl = 1'b0; waitQ();
  endtask

  task automatic readBit(output logic b, output logic steady);
    logic d0;
    masterSda = 1'b1; waitQ();
    masterScl = 1'b1; waitQ();
    b = sdaLine; d0 = sdaDriveLow;
    waitQ();
    steady = (d0 == sdaDriveLow);
    masterScl = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    logic b, st;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b, st);
    ack = ~b;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] v, output logic steadyAll);
    logic b, st;
    steadyAll = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      readBit(b, st);
      v[i] = b;
      steadyAll = steadyAll & st;
    end
    writeBit(~giveAck);
  endtask

  // One data bit with a short pulse: onScl=0 puts an SDA pulse inside SCL high,
  // onScl=1 puts an SCL high pulse inside SCL low.
  task automatic glitchBit(input logic b, input logic onScl);
    masterSda = b;
    if (onScl) begin
      repeat (10) @(negedge clk);
      masterScl = 1'b1; repeat (2) @(negedge clk);
      masterScl = 1'b0; repeat (Q - 12) @(negedge clk);
    end else begin
      waitQ();
    end
    masterScl = 1'b1; waitQ();
    if (!onScl) begin
      masterSda = ~b; repeat (2) @(negedge clk);
      masterSda = b;  repeat (Q - 2) @(negedge clk);
    end else begin
      waitQ();
    end
    masterScl = 1'b0; waitQ();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic       ack, steady;
    logic [7:0] rd;
    int         snap;

    repeat (5) @(negedge clk);
    check("R1 swEn in reset", swEn, 8'h00);
    check("R1 sda in reset", sdaDriveLow, 1'b0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 swEn after reset", swEn, 8'h00);

    // Table walk: R2 address match, R3 mismatch, R4 single write
    for (int k = 0; k < 8; k++) begin
      {strapA1, strapA0} = VEC[k][26:25];
      snap = driveCount;
      startCond();
      writeByte(VEC[k][24:17], ack);
      check($sformatf("R2 ack row %0d", k), ack, VEC[k][8]);
      writeByte(VEC[k][16:9], ack);
      check($sformatf("R4 data ack row %0d", k), ack, VEC[k][8]);
      check($sformatf("R4 swEn row %0d", k), swEn, VEC[k][7:0]);
      if (!VEC[k][8]) check($sformatf("R3 no drive row %0d", k), driveCount - snap, 0);
      stopCond();
    end

    // R5: several data bytes in one write
    strapA1 = 1'b0; strapA0 = 1'b0;
    startCond();
    writeByte(8'h90, ack);
    writeByte(8'h11, ack); check("R5 byte1", swEn, 8'h11);
    writeByte(8'h22, ack); check("R5 byte2", swEn, 8'h22);
    writeByte(8'h3C, ack); check("R5 byte3", swEn, 8'h3C);
    check("R5 ack", ack, 1'b1);
    stopCond();

    // R6 / R7 / R11: read with ack, read again, then no-ack
    startCond();
    writeByte(8'h90, ack);
    writeByte(8'hC3, ack);
    stopCond();
    startCond();
    writeByte(8'h91, ack);
    check("R6 read addr ack", ack, 1'b1);
    readByte(1'b1, rd, steady);
    check("R6 read value", rd, 8'hC3);
    check("R11 sda steady while scl high", steady, 1'b1);
    readByte(1'b0, rd, steady);
    check("R7 repeat read value", rd, 8'hC3);
    check("R7 released after nack", sdaDriveLow, 1'b0);
    snap = driveCount;
    readBit(ack, steady);
    check("R7 idle after nack", driveCount - snap, 0);
    stopCond();

    // R8: repeated START keeps the register and re-enters address reception
    startCond();
    writeByte(8'h90, ack);
    writeByte(8'h44, ack);
    startCond();
    writeByte(8'h91, ack);
    check("R8 addr ack after repeated start", ack, 1'b1);
    readByte(1'b0, rd, steady);
    check("R8 register kept", rd, 8'h44);
    check("R8 swEn kept", swEn, 8'h44);
    stopCond();

    // R9: traffic without START after a STOP is ignored
    snap = driveCount;
    writeByte(8'h90, ack);
    writeByte(8'hEE, ack);
    check("R9 swEn unchanged", swEn, 8'h44);
    check("R9 no sda drive", driveCount - snap, 0);
    stopCond();

    // R10: short pulses on SDA (SCL high) and SCL (SCL low) are ignored
    startCond();
    writeByte(8'h90, ack);
    for (int i = 7; i >= 0; i--) begin
      if (i == 6)      glitchBit(1'b1, 1'b0);
      else if (i == 4) glitchBit(1'b0, 1'b1);
      else             writeBit(8'h6E >> i);
    end
    readBit(ack, steady);
    check("R10 ack after glitches", ack, 1'b0);
    check("R10 swEn after glitches", swEn, 8'h6E);
    stopCond();

    // R1: clear in the middle of operation
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 mid-run clear", swEn, 8'h00);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    startCond();
    writeByte(8'h90, ack);
    writeByte(8'h5A, ack);
    check("R1 write after clear", swEn, 8'h5A);
    stopCond();

    summary();
    $finish;
  end

endmodule